// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation buffer after a miss. On a miss request it takes a 32-bit virtual address and the current root pointer, reads a first-level table entry from physical memory, and uses that entry to find and read a second-level entry. A present second-level entry comes back as a refill: a physical page number and three permission bits. If either entry is not present, the walk stops and a fault is returned for the original access.

Table memory sits behind a simple read port. A request is held until the memory accepts it, and one response returns later. Every table address is physical and is used without translation. Only one walk runs at a time, and the block reports busy from acceptance until the result pulse has ended.

Top module: `pt_walker`

## Requirements
- R1: During and right after reset the block is idle: busy, mem_req_valid, refill_valid and fault_valid are all low.
- R2: The first read targets root_ptr + 4 × va[31:22], using root_ptr and va as sampled at acceptance. mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen high at a clock edge.
- R3: The second read targets {entry1[31:12], 12'h000} + 4 × va[21:12]. Bits 11:0 of the first-level entry have no effect on this address.
- R4: An entry is present when its bit 0 is 1. A non-present first-level entry ends the walk with a one-cycle fault_valid pulse and fault_level = 0, and no second read is issued.
- R5: A non-present second-level entry ends the walk with a one-cycle fault_valid pulse and fault_level = 1.
- R6: A present second-level entry ends the walk with a one-cycle refill_valid pulse. refill_ppn equals entry2[31:12], and refill_perm equals entry2[3:1]: bit 0 is read, bit 1 is write, bit 2 is user.
- R7: refill_valid and fault_valid never go high together. Each lasts exactly one cycle, and the block is idle in the cycle after it. During the pulse, result_va equals the accepted virtual address.
- R8: A miss is accepted only when the block is idle. busy is high from the cycle after acceptance until the result pulse ends. miss_valid, miss_va and root_ptr have no effect while busy, including during the result pulse.
- R9: At most one table read is outstanding. After a request is accepted, no new request is raised until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request |
| miss_va | input | 32 | Virtual address that missed |
| root_ptr | input | 32 | Physical address of the first-level table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | 32 | Physical address of the table entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read |
| refill_valid | output | 1 | Refill result pulse |
| refill_ppn | output | 20 | Physical page number for the refill |
| refill_perm | output | 3 | Permissions {user, write, read} |
| fault_valid | output | 1 | Fault result pulse |
| fault_level | output | 1 | 0 = first level absent, 1 = second level absent |
| result_va | output | 32 | Virtual address of the finished walk |

## Verification
Two events can land in the same cycle: a result pulse, and a new miss request that is already waiting. The bench holds miss_valid high, with unrelated address and root values, through every busy cycle including the pulse. It then presents the next real miss with no gap. The cycle-level model expects the pulse to leave that request untouched, and expects the request to be taken in the following idle cycle, so that the next first-level address comes from the new request alone. Memory stalls and longer response latencies move the pulse against this pending request across several walks.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 32;
  localparam int IDX_W    = 10;
  localparam int OFF_W    = 12;
  localparam int PTE_W    = 32;
  localparam int ENTRY_SH = 2;               // 4-byte entries
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int PERM_W   = 3;
  localparam int RSVD_W   = PTE_W - PPN_W - PERM_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_L1, ST_WAIT_L1, ST_READ_L2, ST_WAIT_L2, ST_DONE, ST_FAULT
  } walk_state_e;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [RSVD_W-1:0] rsvd;
    logic [PERM_W-1:0] perm;   // {user, write, read}
    logic              present;
  } pte_t;

  function automatic logic [IDX_W-1:0] dir_index(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] leaf_index(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return base + (PA_W'(idx) << ENTRY_SH);
  endfunction

  function automatic logic [PA_W-1:0] table_base(input pte_t e);
    return {e.ppn, {OFF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0]  raw,
  output logic              present,
  output logic [PA_W-1:0]   next_base,
  output logic [PPN_W-1:0]  ppn,
  output logic [PERM_W-1:0] perm
);
  pte_t e;
  always_comb begin
    e         = pte_t'(raw);
    present   = e.present;
    next_base = table_base(e);
    ppn       = e.ppn;
    perm      = e.perm;
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_present,
  output logic accept,
  output logic cap_dir,
  output logic cap_leaf,
  output logic sel_leaf,
  output logic mem_req_valid,
  output logic busy,
  output logic done_pulse,
  output logic fault_pulse,
  output logic fault_lvl
);
  walk_state_e state, state_n;
  logic fault_lvl_n;

  // named events
  logic waiting, rsp_fire, req_fire;
  assign waiting  = (state == ST_WAIT_L1) || (state == ST_WAIT_L2);
  assign rsp_fire = waiting && mem_rsp_valid;
  assign req_fire = mem_req_valid && mem_req_ready;

  assign accept        = (state == ST_IDLE) && miss_valid;
  assign mem_req_valid = (state == ST_READ_L1) || (state == ST_READ_L2);
  assign sel_leaf      = (state == ST_READ_L2);
  assign cap_dir       = (state == ST_WAIT_L1) && mem_rsp_valid && rsp_present;
  assign cap_leaf      = (state == ST_WAIT_L2) && mem_rsp_valid && rsp_present;
  assign busy          = (state != ST_IDLE);
  assign done_pulse    = (state == ST_DONE);
  assign fault_pulse   = (state == ST_FAULT);

  always_comb begin
    state_n     = state;
    fault_lvl_n = fault_lvl;
    unique case (state)
      ST_IDLE:    if (miss_valid) state_n = ST_READ_L1;
      ST_READ_L1: if (mem_req_ready) state_n = ST_WAIT_L1;
      ST_WAIT_L1: if (mem_rsp_valid) begin
                    if (rsp_present) state_n = ST_READ_L2;
                    else begin state_n = ST_FAULT; fault_lvl_n = 1'b0; end
                  end
      ST_READ_L2: if (mem_req_ready) state_n = ST_WAIT_L2;
      ST_WAIT_L2: if (mem_rsp_valid) begin
                    if (rsp_present) state_n = ST_DONE;
                    else begin state_n = ST_FAULT; fault_lvl_n = 1'b1; end
                  end
      ST_DONE:    state_n = ST_IDLE;
      ST_FAULT:   state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fault_lvl <= 1'b0;
    end else begin
      state     <= state_n;
      fault_lvl <= fault_lvl_n;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !mem_req_valid); // R9
  AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && !rsp_present) |=> fault_pulse); // R4
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pulse && fault_pulse)); // R7
  AST_PULSE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse || fault_pulse) |=> !busy); // R7
  AST_START_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(miss_valid)); // R8
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cap_dir,
  input  logic              cap_leaf,
  input  logic              sel_leaf,
  input  logic              busy,
  input  logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic [VA_W-1:0]   miss_va,
  input  logic [PA_W-1:0]   root_ptr,
  input  logic [PA_W-1:0]   dir_next_base,
  input  logic [PPN_W-1:0]  rsp_ppn,
  input  logic [PERM_W-1:0] rsp_perm,
  output logic [PA_W-1:0]   req_addr,
  output logic [VA_W-1:0]   va_q,
  output logic [PPN_W-1:0]  ppn_q,
  output logic [PERM_W-1:0] perm_q
);
  logic [PA_W-1:0] root_q, leaf_base_q;
  logic [PA_W-1:0] dir_slot, leaf_slot;

  assign dir_slot  = slot_addr(root_q, dir_index(va_q));
  assign leaf_slot = slot_addr(leaf_base_q, leaf_index(va_q));
  assign req_addr  = sel_leaf ? leaf_slot : dir_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q        <= '0;
      root_q      <= '0;
      leaf_base_q <= '0;
      ppn_q       <= '0;
      perm_q      <= '0;
    end else begin
      if (accept) begin
        va_q   <= miss_va;
        root_q <= root_ptr;
      end
      if (cap_dir) leaf_base_q <= dir_next_base;
      if (cap_leaf) begin
        ppn_q  <= rsp_ppn;
        perm_q <= rsp_perm;
      end
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(req_addr)); // R2
  AST_VA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(va_q)); // R8
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [VA_W-1:0]   miss_va,
  input  logic [PA_W-1:0]   root_ptr,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              refill_valid,
  output logic [PPN_W-1:0]  refill_ppn,
  output logic [PERM_W-1:0] refill_perm,
  output logic              fault_valid,
  output logic              fault_level,
  output logic [VA_W-1:0]   result_va
);
  logic              accept, cap_dir, cap_leaf, sel_leaf;
  logic              rsp_present;
  logic [PA_W-1:0]   rsp_base;
  logic [PPN_W-1:0]  rsp_ppn;
  logic [PERM_W-1:0] rsp_perm;

  ptw_pte_dec u_dec (
    .raw       (mem_rsp_data),
    .present   (rsp_present),
    .next_base (rsp_base),
    .ppn       (rsp_ppn),
    .perm      (rsp_perm)
  );

  ptw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_present   (rsp_present),
    .accept        (accept),
    .cap_dir       (cap_dir),
    .cap_leaf      (cap_leaf),
    .sel_leaf      (sel_leaf),
    .mem_req_valid (mem_req_valid),
    .busy          (busy),
    .done_pulse    (refill_valid),
    .fault_pulse   (fault_valid),
    .fault_lvl     (fault_level)
  );

  ptw_datapath u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .cap_dir       (cap_dir),
    .cap_leaf      (cap_leaf),
    .sel_leaf      (sel_leaf),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .miss_va       (miss_va),
    .root_ptr      (root_ptr),
    .dir_next_base (rsp_base),
    .rsp_ppn       (rsp_ppn),
    .rsp_perm      (rsp_perm),
    .req_addr      (mem_req_addr),
    .va_q          (result_va),
    .ppn_q         (refill_ppn),
    .perm_q        (refill_perm)
  );
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [31:0] miss_va = '0, root_ptr = '0;
  logic busy, mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_rsp_data = '0, result_va;
  logic refill_valid, fault_valid, fault_level;
  logic [19:0] refill_ppn;
  logic [2:0] refill_perm;

  always #2.5 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_va(miss_va),
    .root_ptr(root_ptr), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .refill_valid(refill_valid), .refill_ppn(refill_ppn), .refill_perm(refill_perm),
    .fault_valid(fault_valid), .fault_level(fault_level), .result_va(result_va)
  );

  int checks = 0, failures = 0;
  logic [31:0] mem [logic [31:0]];

  // reference model state: 0 idle,1 read dir,2 wait dir,3 read leaf,4 wait leaf,5 refill,6 fault
  int mp = 0;
  logic [31:0] m_va, m_root, m_e1, m_leaf, pend_addr;
  logic m_flvl;
  int timer = -1, lat = 1, ready_mode = 0, cyc = 0;
  bit noise = 0;
  int seen_refill, seen_fault;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int phase);
    if (phase == 1) return m_root + ((m_va >> 22) * 4);
    return (m_e1 & 32'hFFFF_F000) + (((m_va >> 12) & 32'd1023) * 4);
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic step();
    bit hs, rv;
    int old;
    // compare at negedge
    chk("R8 busy", 32'(busy), 32'(mp != 0));
    chk("R9 req_valid", 32'(mem_req_valid), 32'(mp == 1 || mp == 3));
    if (mp == 1) chk("R2 dir addr", mem_req_addr, exp_addr(1));
    if (mp == 3) chk("R3 leaf addr", mem_req_addr, exp_addr(3));
    chk("R7 refill pulse", 32'(refill_valid), 32'(mp == 5));
    chk("R7 fault pulse", 32'(fault_valid), 32'(mp == 6));
    if (mp == 5) begin
      chk("R6 ppn", 32'(refill_ppn), m_leaf >> 12);
      chk("R6 perm", 32'(refill_perm), (m_leaf >> 1) & 32'd7);
      chk("R7 va", result_va, m_va);
    end
    if (mp == 6) begin
      chk("R4 R5 level", 32'(fault_level), 32'(m_flvl));
      chk("R7 va", result_va, m_va);
    end
    seen_refill += int'(refill_valid);
    seen_fault  += int'(fault_valid);
    // drive inputs
    if (mp != 0) begin
      if (noise) begin
        miss_valid = 1'b1; miss_va = $urandom; root_ptr = $urandom;
      end else miss_valid = 1'b0;
    end
    mem_req_ready = (ready_mode == 0) ? 1'b1 : cyc[0];
    rv = (timer == 0);
    mem_rsp_valid = rv;
    mem_rsp_data = rv ? rd(pend_addr) : 32'hDEAD_BEEF;
    @(posedge clk);
    old = mp;
    hs = (old == 1 || old == 3) && mem_req_ready;
    case (old)
      0: if (miss_valid) begin m_va = miss_va; m_root = root_ptr; mp = 1; end
      1: if (mem_req_ready) mp = 2;
      2: if (rv) begin
           if (!mem_rsp_data[0]) begin mp = 6; m_flvl = 1'b0; end
           else begin m_e1 = mem_rsp_data; mp = 3; end
         end
      3: if (mem_req_ready) mp = 4;
      4: if (rv) begin
           if (!mem_rsp_data[0]) begin mp = 6; m_flvl = 1'b1; end
           else begin m_leaf = mem_rsp_data; mp = 5; end
         end
      default: mp = 0;
    endcase
    if (rv) timer = -1;
    else if (timer > 0) timer--;
    if (hs) begin pend_addr = exp_addr(old); timer = lat - 1; end
    cyc++;
    @(negedge clk);
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] root,
                      input bit want_refill, input string tag);
    int guard = 0;
    seen_refill = 0; seen_fault = 0;
    miss_valid = 1'b1; miss_va = va; root_ptr = root;
    step();
    while (mp != 0 && guard < 200) begin
      step();
      guard++;
    end
    chk({tag, " refill count"}, seen_refill, want_refill ? 1 : 0);
    chk({tag, " fault count"}, seen_fault, want_refill ? 0 : 1);
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // table contents
    mem[32'h0001_0000 + 4*1]    = 32'h0002_0001;
    mem[32'h0002_0000 + 4*3]    = 32'hABCD_E00B;  // perm 101
    mem[32'h0001_0000 + 4*1023] = 32'h0003_0001;
    mem[32'h0003_0000 + 4*1023] = 32'h1234_5003;  // perm 001
    mem[32'h0008_0000]          = 32'h0004_0FFF;  // low bits must not move the base
    mem[32'h0004_0000 + 4*2]    = 32'h5555_500F;  // perm 111
    mem[32'h0004_0000 + 4*5]    = 32'h7777_7006;  // not present

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req", 32'(mem_req_valid), 0);
    chk("R1 refill", 32'(refill_valid), 0);
    chk("R1 fault", 32'(fault_valid), 0);
    rst_n = 1'b1;
    step();

    walk(32'h0040_3123, 32'h0001_0000, 1, "R6 basic");
    walk(32'h0140_0000, 32'h0001_0000, 0, "R4 dir absent");
    walk(32'h0040_7000, 32'h0001_0000, 0, "R5 leaf absent");
    walk(32'hFFFF_FFFF, 32'h0001_0000, 1, "R6 max index");
    walk(32'h0000_2ABC, 32'h0008_0000, 1, "R3 other root");
    walk(32'h0000_5000, 32'h0008_0000, 0, "R5 present bit only");

    // stalls and latency
    ready_mode = 1; lat = 3;
    walk(32'h0040_3FFF, 32'h0001_0000, 1, "R2 stalled");
    walk(32'h0380_0000, 32'h0001_0000, 0, "R4 stalled");

    // pending miss overlaps the result pulse; busy-time inputs ignored
    noise = 1; lat = 2;
    walk(32'hFFFF_F000, 32'h0001_0000, 1, "R8 noise a");
    walk(32'h0000_2000, 32'h0008_0000, 1, "R8 back to back");
    ready_mode = 0; lat = 1;
    walk(32'h0040_3000, 32'h0001_0000, 1, "R8 noise b");
    noise = 0;
    miss_valid = 1'b0;
    repeat (3) step();
    chk("R1 idle after run", 32'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule